// File: doc/BRIEF.md
# Timer Channel Compare Output Stage

This block turns compare events from a timer channel into a waveform bit and places that bit on a general-purpose pin. It keeps one internal waveform level in a flip-flop. The timer pulses a match strobe when its counter hits the compare value. Software can also pulse a force strobe. On either strobe, a 2-bit action field decides whether the level is kept, inverted, driven low or driven high.

The level is separate from the pin. When the action field is nonzero, the level replaces the ordinary port data bit as the pin's data. When the field is zero, the port bit passes through unchanged. The pin's output enable always follows the direction bit and nothing else. Software can therefore write a starting level while the pin is still an input, and the waveform begins from a known value once the direction bit is set.

All interfaces are plain control and data levels. The block carries no streamed data, so there is no valid/ready handshake.

Top module: `cmo_unit`

## Requirements
- R1: After reset the internal level is 0; with action field 11 and no strobe, pin_out reads 0.
- R2: With action field 00, a match or force strobe leaves the internal level unchanged.
- R3: With action field 01, a strobe inverts the internal level at the next clock edge.
- R4: With action field 10, a strobe drives the internal level to 0 at the next clock edge.
- R5: With action field 11, a strobe drives the internal level to 1 at the next clock edge.
- R6: A one-cycle force strobe applies the same action as a match strobe. A match and a force in the same cycle apply the action once.
- R7: A level write (lvl_wr=1) loads lvl_wdata at the next edge and takes priority over any strobe in the same cycle.
- R8: pin_out equals the internal level when either bit of the action field is 1, and equals port_bit when the field is 00. It is combinational in both cases.
- R9: pin_oe equals dir_bit at all times, whatever the action field holds.
- R10: A level write takes effect while dir_bit is 0. The written level then appears on pin_out once the field is nonzero, and pin_oe stays 0 until dir_bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_match | input | 1 | One-cycle compare-match strobe from the timer |
| cmp_force | input | 1 | One-cycle software force strobe |
| cmp_mode | input | 2 | Action field: 00 hold, 01 invert, 10 clear, 11 set |
| lvl_wr | input | 1 | Write strobe that loads the internal level |
| lvl_wdata | input | 1 | Value loaded by lvl_wr |
| port_bit | input | 1 | Ordinary port data bit |
| dir_bit | input | 1 | Data-direction bit, 1 = output |
| pin_out | output | 1 | Data value driven to the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
The internal level is the only registered result. A strobe or write lands on it at the clock edge that samples the request, so its effect on pin_out is due one edge after the request. pin_out and pin_oe also follow cmp_mode, port_bit and dir_bit in the same cycle, with no register in between. The bench changes inputs on the falling edge and samples 2 ns after the following rising edge. At that point the registered update has settled and the inputs that drive the combinational paths are still held, so both kinds of result are read in the cycle they are due. The internal level is hidden when the field is 00. The bench reads it by switching the field to a nonzero code without a strobe and observing pin_out.

// File: rtl/cmo_pkg.sv
package cmo_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CM_HOLD   = 2'b00,
    CM_TOGGLE = 2'b01,
    CM_CLEAR  = 2'b10,
    CM_SET    = 2'b11
  } cm_mode_e;

  localparam logic LVL_RESET = 1'b0;
endpackage

// File: rtl/cmo_action.sv
module cmo_action
  import cmo_pkg::*;
(
  input  logic              cur_lvl,
  input  logic [MODE_W-1:0] mode,
  output logic              nxt_lvl
);
  always_comb begin
    unique case (cm_mode_e'(mode))
      CM_HOLD:   nxt_lvl = cur_lvl;
      CM_TOGGLE: nxt_lvl = ~cur_lvl;
      CM_CLEAR:  nxt_lvl = 1'b0;
      CM_SET:    nxt_lvl = 1'b1;
      default:   nxt_lvl = cur_lvl;
    endcase
  end
endmodule

// File: rtl/cmo_state.sv
module cmo_state
  import cmo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wr,
  input  logic wdata,
  input  logic nxt_lvl,
  output logic lvl_q
);
  // a write outranks any compare event in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lvl_q <= LVL_RESET;
    else if (wr)  lvl_q <= wdata;
    else if (evt) lvl_q <= nxt_lvl;
  end
endmodule

// File: rtl/cmo_pinmux.sv
module cmo_pinmux
  import cmo_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              lvl,
  input  logic              port_bit,
  input  logic              dir_bit,
  output logic              pin_out,
  output logic              pin_oe
);
  logic ovr;
  assign ovr     = |mode;
  assign pin_out = ovr ? lvl : port_bit;
  assign pin_oe  = dir_bit;
endmodule

// File: rtl/cmo_unit.sv
module cmo_unit
  import cmo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_match,
  input  logic              cmp_force,
  input  logic [MODE_W-1:0] cmp_mode,
  input  logic              lvl_wr,
  input  logic              lvl_wdata,
  input  logic              port_bit,
  input  logic              dir_bit,
  output logic              pin_out,
  output logic              pin_oe
);
  logic oc_q;
  logic oc_nxt;
  logic oc_evt;

  assign oc_evt = cmp_match | cmp_force;

  cmo_action u_act (
    .cur_lvl (oc_q),
    .mode    (cmp_mode),
    .nxt_lvl (oc_nxt)
  );

  cmo_state u_st (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (oc_evt),
    .wr      (lvl_wr),
    .wdata   (lvl_wdata),
    .nxt_lvl (oc_nxt),
    .lvl_q   (oc_q)
  );

  cmo_pinmux u_mux (
    .mode     (cmp_mode),
    .lvl      (oc_q),
    .port_bit (port_bit),
    .dir_bit  (dir_bit),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );
endmodule

// File: rtl/cmo_unit_chk.sv
module cmo_unit_chk
  import cmo_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_match,
  input logic              cmp_force,
  input logic [MODE_W-1:0] cmp_mode,
  input logic              lvl_wr,
  input logic              lvl_wdata,
  input logic              port_bit,
  input logic              dir_bit,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              oc_q
);
  logic ev;
  assign ev = (cmp_match | cmp_force) & ~lvl_wr;

  a_r1_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !oc_q);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && cmp_mode == 2'b00) |=> $stable(oc_q));
  a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && cmp_mode == 2'b01) |=> (oc_q != $past(oc_q)));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && cmp_mode == 2'b10) |=> !oc_q);
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && cmp_mode == 2'b11) |=> oc_q);
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_match && !cmp_force && !lvl_wr) |=> $stable(oc_q));
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> (oc_q == $past(lvl_wdata)));
  a_r8_override: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode != 2'b00) |-> (pin_out == oc_q));
  a_r8_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode == 2'b00) |-> (pin_out == port_bit));
  a_r9_dir: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == dir_bit);
endmodule

bind cmo_unit cmo_unit_chk chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmp_match (cmp_match),
  .cmp_force (cmp_force),
  .cmp_mode  (cmp_mode),
  .lvl_wr    (lvl_wr),
  .lvl_wdata (lvl_wdata),
  .port_bit  (port_bit),
  .dir_bit   (dir_bit),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .oc_q      (oc_q)
);

// File: tb/cmo_unit_test.sv
`timescale 1ns/1ps
module cmo_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic cmp_match = 1'b0, cmp_force = 1'b0, lvl_wr = 1'b0, lvl_wdata = 1'b0;
  logic port_bit = 1'b0, dir_bit = 1'b0;
  logic [1:0] cmp_mode = 2'b00;
  logic pin_out, pin_oe;
  logic exp_lvl;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmo_unit uut (
    .clk(clk), .rst_n(rst_n), .cmp_match(cmp_match), .cmp_force(cmp_force),
    .cmp_mode(cmp_mode), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
    .port_bit(port_bit), .dir_bit(dir_bit), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic model_next(logic s, logic m, logic f, logic [1:0] md,
                                      logic w, logic wd);
    if (w) return wd;
    if (!(m | f)) return s;
    case (md)
      2'b01:   return ~s;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return s;
    endcase
  endfunction

  function automatic logic model_pin(logic s, logic [1:0] md, logic pb);
    return (md != 2'b00) ? s : pb;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // drive on falling edge, sample 2 ns after the rising edge
  task automatic step(logic m, logic f, logic [1:0] md, logic w, logic wd,
                      logic pb, logic db, string tag);
    @(negedge clk);
    cmp_match = m; cmp_force = f; cmp_mode = md; lvl_wr = w; lvl_wdata = wd;
    port_bit = pb; dir_bit = db;
    @(posedge clk);
    exp_lvl = model_next(exp_lvl, m, f, md, w, wd);
    #2;
    chk({tag, " pin_out"}, pin_out, model_pin(exp_lvl, md, pb));
    chk("R9 pin_oe", pin_oe, db);
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_lvl = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: level reads 0 after reset
    step(0, 0, 2'b11, 0, 0, 1, 1, "R1");
    // R10: preset with direction as input
    step(0, 0, 2'b00, 1, 1, 0, 0, "R10");
    chk("R10 oe low while preset", pin_oe, 1'b0);
    step(0, 0, 2'b11, 0, 0, 0, 0, "R10");
    step(0, 0, 2'b11, 0, 0, 0, 1, "R10");
    // R2: hold, then reveal
    step(1, 0, 2'b00, 0, 0, 0, 1, "R2");
    step(0, 0, 2'b01, 0, 0, 0, 1, "R2");
    // R3: toggle twice
    step(1, 0, 2'b01, 0, 0, 0, 1, "R3");
    step(1, 0, 2'b01, 0, 0, 0, 1, "R3");
    // R4 / R5
    step(1, 0, 2'b10, 0, 0, 1, 1, "R4");
    step(1, 0, 2'b11, 0, 0, 0, 1, "R5");
    // R6: force alone, then both strobes toggle once
    step(0, 1, 2'b10, 0, 0, 1, 1, "R6");
    step(0, 1, 2'b01, 0, 0, 0, 1, "R6");
    step(1, 1, 2'b01, 0, 0, 0, 1, "R6");
    // R7: write beats set match and force
    step(1, 1, 2'b11, 0, 0, 0, 1, "R7");
    step(1, 1, 2'b11, 1, 0, 1, 1, "R7");
    // R8: pass-through
    step(0, 0, 2'b00, 0, 0, 1, 1, "R8");
    step(0, 0, 2'b00, 0, 0, 0, 0, "R8");
    void'($urandom(32'd2024));
    for (int i = 0; i < 600; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[0], r[1] & r[2], r[4:3], r[5] & r[6], r[7], r[2], r[6], "R8 rnd");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule